// File: doc/BRIEF.md
# Projective Road Muon Track Finder

This block is the tracking core of one detector tower. Each clock it receives a hit bitmap for each of five stations laid along one projective coordinate. Every hit in the third station seeds a track search. Each seed projects straight back towards the interaction point. It looks for confirming hits inside a programmable search window in the second, fourth and fifth stations. All seeds are evaluated in parallel with plain bitmap logic and small index offsets. No fitting arithmetic is used.

Stations two and three share the fine pitch. Station one is twice as coarse and stations four and five are four times as coarse. A seed at fine index `i` therefore looks at index `i/2` in station one and at index `i/4` in stations four and five. An accepted seed reports three things: its own index, the nearest station-two hit, and the nearest station-one hit. The station-one hit is found around the point given by the straight line through the seed and the chosen station-two hit. At most two accepted seeds are reported per clock, in two output slots.

Top module: `trk_road_finder`

## Requirements
- R1: A seed at station-three index `i` is accepted only when station two, station four and station five each have at least one hit inside their windows. The station-two window is `[i-w2, i+w2]`. The station-four window is `[i/4-w4, i/4+w4]` and the station-five window is `[i/4-w5, i/4+w5]`, where `/` truncates.
- R2: The reported station-two index is the hit in the window nearest to `i`. When two hits are equally near, the lower index is reported.
- R3: Let `j` be the chosen station-two index. The station-one search centre is `i/2 + (j - i)` and the window half-width is `w1`. The nearest hit wins and the lower index wins a tie. If the window holds no hit, the seed is still reported, with the station-one valid bit low.
- R4: Each half-width is a 3-bit value from 0 to 7 pads. A width of 0 searches only the centre pad. Window positions below 0 or beyond the last pad of a station count as no hit.
- R5: Slot 0 carries the accepted seed with the lowest index and slot 1 carries the next lowest. Further accepted seeds are dropped. Slot 1 is never valid while slot 0 is invalid.
- R6: Bitmaps and widths presented before a rising edge produce their results on the outputs after the following rising edge. The latency is two clocks, with no input handshake.
- R7: While reset is asserted, both slot valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitS1 | input | SEEDS/2 | Station-one hit bitmap |
| hitS2 | input | SEEDS | Station-two hit bitmap |
| hitS3 | input | SEEDS | Station-three (seed) hit bitmap |
| hitS4 | input | SEEDS/4 | Station-four hit bitmap |
| hitS5 | input | SEEDS/4 | Station-five hit bitmap |
| win1 | input | 3 | Station-one window half-width |
| win2 | input | 3 | Station-two window half-width |
| win4 | input | 3 | Station-four window half-width |
| win5 | input | 3 | Station-five window half-width |
| cand0Valid | output | 1 | Slot 0 holds a track |
| cand0Seed | output | 8 | Slot 0 seed index |
| cand0S2 | output | 8 | Slot 0 station-two index |
| cand0S1Valid | output | 1 | Slot 0 station-one hit found |
| cand0S1 | output | 8 | Slot 0 station-one index |
| cand1Valid | output | 1 | Slot 1 holds a track |
| cand1Seed | output | 8 | Slot 1 seed index |
| cand1S2 | output | 8 | Slot 1 station-two index |
| cand1S1Valid | output | 1 | Slot 1 station-one hit found |
| cand1S1 | output | 8 | Slot 1 station-one index |

## Verification
The bench builds the block with SEEDS = 32, which gives 16 station-one pads and 8 pads in each of stations four and five. At that size a 7-pad window often runs past both ends of a station, so the out-of-tower rule of R4 is exercised in almost every random cycle. Random bitmaps also produce more than two accepted seeds often enough to test the drop rule of R5 regularly. The smaller size also keeps equal-distance ties frequent enough for R2 and R3.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int IDX_W = 8;

  // result of one seed evaluation
  typedef struct packed {
    logic             found;
    logic [IDX_W-1:0] s2;
    logic             s1Valid;
    logic [IDX_W-1:0] s1;
  } seedRes_t;

  // one reported candidate
  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] seed;
    logic [IDX_W-1:0] s2;
    logic             s1Valid;
    logic [IDX_W-1:0] s1;
  } cand_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             load0;
    logic             load1;
    logic [IDX_W-1:0] idx0;
    logic [IDX_W-1:0] idx1;
  } selStrobes_t;
endpackage

// File: rtl/trk_seed_unit.sv
module trk_seed_unit
  import trk_pkg::*;
#(
  parameter int SEEDS = 96,
  parameter int I     = 0
) (
  input  logic               s3Bit,
  input  logic [SEEDS/2-1:0] s1,
  input  logic [SEEDS-1:0]   s2,
  input  logic [SEEDS/4-1:0] s4,
  input  logic [SEEDS/4-1:0] s5,
  input  logic [2:0]         w1,
  input  logic [2:0]         w2,
  input  logic [2:0]         w4,
  input  logic [2:0]         w5,
  output seedRes_t           res
);
  localparam int N1 = SEEDS / 2;
  localparam int N4 = SEEDS / 4;
  localparam int C1 = I / 2;
  localparam int C4 = I / 4;

  function automatic logic atFine(input logic [SEEDS-1:0] v, input int k);
    logic [SEEDS-1:0] t;
    if (k < 0 || k >= SEEDS) return 1'b0;
    t = v >> k;
    return t[0];
  endfunction

  function automatic logic atHalf(input logic [N1-1:0] v, input int k);
    logic [N1-1:0] t;
    if (k < 0 || k >= N1) return 1'b0;
    t = v >> k;
    return t[0];
  endfunction

  function automatic logic atQuarter(input logic [N4-1:0] v, input int k);
    logic [N4-1:0] t;
    if (k < 0 || k >= N4) return 1'b0;
    t = v >> k;
    return t[0];
  endfunction

  logic s2Found, s1Found, s4Any, s5Any;
  int   s2Pos, s1Pos, c1;

  always_comb begin
    s2Found = 1'b0;
    s2Pos   = 0;
    for (int d = 0; d < 8; d++) begin
      if (!s2Found && d <= int'(w2)) begin
        if (atFine(s2, I - d)) begin
          s2Found = 1'b1;
          s2Pos   = I - d;
        end else if (atFine(s2, I + d)) begin
          s2Found = 1'b1;
          s2Pos   = I + d;
        end
      end
    end
  end

  always_comb begin
    s4Any = 1'b0;
    s5Any = 1'b0;
    for (int d = -7; d < 8; d++) begin
      if (((d < 0) ? -d : d) <= int'(w4) && atQuarter(s4, C4 + d)) s4Any = 1'b1;
      if (((d < 0) ? -d : d) <= int'(w5) && atQuarter(s5, C4 + d)) s5Any = 1'b1;
    end
  end

  always_comb begin
    c1      = C1 + (s2Pos - I);
    s1Found = 1'b0;
    s1Pos   = 0;
    for (int d = 0; d < 8; d++) begin
      if (!s1Found && d <= int'(w1)) begin
        if (atHalf(s1, c1 - d)) begin
          s1Found = 1'b1;
          s1Pos   = c1 - d;
        end else if (atHalf(s1, c1 + d)) begin
          s1Found = 1'b1;
          s1Pos   = c1 + d;
        end
      end
    end
  end

  always_comb begin
    res.found   = s3Bit & s2Found & s4Any & s5Any;
    res.s2      = IDX_W'(s2Pos);
    res.s1Valid = s1Found;
    res.s1      = IDX_W'(s1Pos);
  end
endmodule

// File: rtl/trk_select.sv
module trk_select
  import trk_pkg::*;
#(
  parameter int SEEDS = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEEDS-1:0] found,
  output selStrobes_t      sel
);
  always_comb begin
    sel = '0;
    for (int k = 0; k < SEEDS; k++) begin
      if (found[k]) begin
        if (!sel.load0) begin
          sel.load0 = 1'b1;
          sel.idx0  = IDX_W'(k);
        end else if (!sel.load1) begin
          sel.load1 = 1'b1;
          sel.idx1  = IDX_W'(k);
        end
      end
    end
  end

  // R5: second pick only after a first, and strictly above it
  a_r5_pick_order: assert property (@(posedge clk) disable iff (!rstN)
    sel.load1 |-> (sel.load0 && sel.idx1 > sel.idx0));

  // R5: no accepted seed is skipped when a slot stays empty
  a_r5_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    (found != '0) |-> sel.load0);
endmodule

// File: rtl/trk_datapath.sv
module trk_datapath
  import trk_pkg::*;
#(
  parameter int SEEDS = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEEDS/2-1:0] hitS1,
  input  logic [SEEDS-1:0]   hitS2,
  input  logic [SEEDS-1:0]   hitS3,
  input  logic [SEEDS/4-1:0] hitS4,
  input  logic [SEEDS/4-1:0] hitS5,
  input  logic [2:0]         win1,
  input  logic [2:0]         win2,
  input  logic [2:0]         win4,
  input  logic [2:0]         win5,
  input  selStrobes_t        sel,
  output logic [SEEDS-1:0]   found,
  output cand_t              cand0,
  output cand_t              cand1
);
  localparam int N1 = SEEDS / 2;
  localparam int N4 = SEEDS / 4;

  logic [N1-1:0]    s1Q;
  logic [SEEDS-1:0] s2Q, s3Q;
  logic [N4-1:0]    s4Q, s5Q;
  logic [2:0]       w1Q, w2Q, w4Q, w5Q;

  // stage 1: capture bitmaps and widths
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Q <= '0; s2Q <= '0; s3Q <= '0; s4Q <= '0; s5Q <= '0;
      w1Q <= '0; w2Q <= '0; w4Q <= '0; w5Q <= '0;
    end else begin
      s1Q <= hitS1; s2Q <= hitS2; s3Q <= hitS3; s4Q <= hitS4; s5Q <= hitS5;
      w1Q <= win1;  w2Q <= win2;  w4Q <= win4;  w5Q <= win5;
    end
  end

  seedRes_t res [SEEDS];

  for (genvar g = 0; g < SEEDS; g++) begin : gSeed
    trk_seed_unit #(.SEEDS(SEEDS), .I(g)) u_seed (
      .s3Bit(s3Q[g]), .s1(s1Q), .s2(s2Q), .s4(s4Q), .s5(s5Q),
      .w1(w1Q), .w2(w2Q), .w4(w4Q), .w5(w5Q), .res(res[g])
    );
    assign found[g] = res[g].found;
  end

  cand_t next0, next1;

  always_comb begin
    next0 = '0;
    next1 = '0;
    for (int k = 0; k < SEEDS; k++) begin
      if (sel.load0 && int'(sel.idx0) == k)
        next0 = '{valid: 1'b1, seed: IDX_W'(k), s2: res[k].s2,
                  s1Valid: res[k].s1Valid, s1: res[k].s1};
      if (sel.load1 && int'(sel.idx1) == k)
        next1 = '{valid: 1'b1, seed: IDX_W'(k), s2: res[k].s2,
                  s1Valid: res[k].s1Valid, s1: res[k].s1};
    end
  end

  // stage 2: candidate records
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand0 <= '0;
      cand1 <= '0;
    end else begin
      cand0 <= next0;
      cand1 <= next1;
    end
  end

  // R1: a reported seed came from a hit in the captured seed bitmap
  a_r1_seed_was_hit: assert property (@(posedge clk) disable iff (!rstN)
    cand0.valid |-> ((($past(s3Q) >> cand0.seed) & SEEDS'(1)) != '0));

  // R2: the chosen station-two hit lies inside the window that was in force
  a_r2_s2_in_window: assert property (@(posedge clk) disable iff (!rstN)
    cand0.valid |-> (((cand0.s2 >= cand0.seed) ? (cand0.s2 - cand0.seed)
                                               : (cand0.seed - cand0.s2))
                     <= {5'b0, $past(w2Q)}));

  // R5: slot 1 only behind slot 0, seeds increasing
  a_r5_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    cand1.valid |-> (cand0.valid && cand1.seed > cand0.seed));

  // R7: outputs clear one clock into reset
  a_r7_reset_clear: assert property (@(posedge clk)
    $past(!rstN) |-> (!cand0.valid && !cand1.valid));
endmodule

// File: rtl/trk_road_finder.sv
module trk_road_finder
  import trk_pkg::*;
#(
  parameter int SEEDS = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEEDS/2-1:0] hitS1,
  input  logic [SEEDS-1:0]   hitS2,
  input  logic [SEEDS-1:0]   hitS3,
  input  logic [SEEDS/4-1:0] hitS4,
  input  logic [SEEDS/4-1:0] hitS5,
  input  logic [2:0]         win1,
  input  logic [2:0]         win2,
  input  logic [2:0]         win4,
  input  logic [2:0]         win5,
  output logic               cand0Valid,
  output logic [7:0]         cand0Seed,
  output logic [7:0]         cand0S2,
  output logic               cand0S1Valid,
  output logic [7:0]         cand0S1,
  output logic               cand1Valid,
  output logic [7:0]         cand1Seed,
  output logic [7:0]         cand1S2,
  output logic               cand1S1Valid,
  output logic [7:0]         cand1S1
);
  logic [SEEDS-1:0] found;
  selStrobes_t      sel;
  cand_t            c0, c1;

  trk_datapath #(.SEEDS(SEEDS)) u_datapath (
    .clk(clk), .rstN(rstN),
    .hitS1(hitS1), .hitS2(hitS2), .hitS3(hitS3), .hitS4(hitS4), .hitS5(hitS5),
    .win1(win1), .win2(win2), .win4(win4), .win5(win5),
    .sel(sel), .found(found), .cand0(c0), .cand1(c1)
  );

  trk_select #(.SEEDS(SEEDS)) u_select (
    .clk(clk), .rstN(rstN), .found(found), .sel(sel)
  );

  assign cand0Valid   = c0.valid;
  assign cand0Seed    = c0.seed;
  assign cand0S2      = c0.s2;
  assign cand0S1Valid = c0.s1Valid;
  assign cand0S1      = c0.s1;
  assign cand1Valid   = c1.valid;
  assign cand1Seed    = c1.seed;
  assign cand1S2      = c1.s2;
  assign cand1S1Valid = c1.s1Valid;
  assign cand1S1      = c1.s1;
endmodule

// File: tb/trk_road_finder_bench.sv
module trk_road_finder_bench;
  localparam int S  = 32;
  localparam int N1 = S / 2;
  localparam int N4 = S / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N1-1:0] hitS1 = '0;
  logic [S-1:0]  hitS2 = '0, hitS3 = '0;
  logic [N4-1:0] hitS4 = '0, hitS5 = '0;
  logic [2:0]    win1 = '0, win2 = '0, win4 = '0, win5 = '0;
  logic          cand0Valid, cand0S1Valid, cand1Valid, cand1S1Valid;
  logic [7:0]    cand0Seed, cand0S2, cand0S1, cand1Seed, cand1S2, cand1S1;

  always #5 clk = ~clk;

  trk_road_finder #(.SEEDS(S)) u_trk_road_finder (
    .clk(clk), .rstN(rstN),
    .hitS1(hitS1), .hitS2(hitS2), .hitS3(hitS3), .hitS4(hitS4), .hitS5(hitS5),
    .win1(win1), .win2(win2), .win4(win4), .win5(win5),
    .cand0Valid(cand0Valid), .cand0Seed(cand0Seed), .cand0S2(cand0S2),
    .cand0S1Valid(cand0S1Valid), .cand0S1(cand0S1),
    .cand1Valid(cand1Valid), .cand1Seed(cand1Seed), .cand1S2(cand1S2),
    .cand1S1Valid(cand1S1Valid), .cand1S1(cand1S1)
  );

  typedef struct packed {
    logic v0; logic [7:0] seed0, s20; logic s1v0; logic [7:0] s10;
    logic v1; logic [7:0] seed1, s21; logic s1v1; logic [7:0] s11;
  } exp_t;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  exp_t  expQ[$];
  string tagQ[$];

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // nearest set bit to centre c within +/-w in a vector of n pads; -1 if none
  function automatic int nearest(input logic [255:0] v, input int n, input int c, input int w);
    for (int d = 0; d <= w; d++) begin
      if (c - d >= 0 && c - d < n && v[c - d]) return c - d;
      if (c + d >= 0 && c + d < n && v[c + d]) return c + d;
    end
    return -1;
  endfunction

  function automatic exp_t refModel(input logic [S-1:0] a3, a2, input logic [N1-1:0] a1,
                                    input logic [N4-1:0] a4, a5,
                                    input int v1, v2, v4, v5);
    exp_t e = '0;
    int cnt = 0;
    for (int i = 0; i < S; i++) begin
      if (a3[i]) begin
        int j = nearest(256'(a2), S, i, v2);
        int k;
        if (j >= 0 && nearest(256'(a4), N4, i / 4, v4) >= 0 &&
            nearest(256'(a5), N4, i / 4, v5) >= 0) begin
          k = nearest(256'(a1), N1, i / 2 + (j - i), v1);
          if (cnt == 0) begin
            e.v0 = 1; e.seed0 = 8'(i); e.s20 = 8'(j); e.s1v0 = (k >= 0); e.s10 = 8'((k >= 0) ? k : 0);
          end else if (cnt == 1) begin
            e.v1 = 1; e.seed1 = 8'(i); e.s21 = 8'(j); e.s1v1 = (k >= 0); e.s11 = 8'((k >= 0) ? k : 0);
          end
          cnt++;
        end
      end
    end
    return e;
  endfunction

  task automatic compareOut(input exp_t e, input string tag);
    check(cand0Valid == e.v0, {tag, " R1 slot0 valid"}, cand0Valid, e.v0);
    check(cand1Valid == e.v1, {tag, " R5 slot1 valid"}, cand1Valid, e.v1);
    if (cand0Valid && e.v0) begin
      check(cand0Seed == e.seed0, {tag, " R5 slot0 seed"}, cand0Seed, e.seed0);
      check(cand0S2 == e.s20, {tag, " R2 slot0 s2"}, cand0S2, e.s20);
      check(cand0S1Valid == e.s1v0, {tag, " R3 slot0 s1 valid"}, cand0S1Valid, e.s1v0);
      if (e.s1v0) check(cand0S1 == e.s10, {tag, " R3 slot0 s1"}, cand0S1, e.s10);
    end
    if (cand1Valid && e.v1) begin
      check(cand1Seed == e.seed1, {tag, " R5 slot1 seed"}, cand1Seed, e.seed1);
      check(cand1S2 == e.s21, {tag, " R2 slot1 s2"}, cand1S2, e.s21);
      check(cand1S1Valid == e.s1v1, {tag, " R3 slot1 s1 valid"}, cand1S1Valid, e.s1v1);
      if (e.s1v1) check(cand1S1 == e.s11, {tag, " R3 slot1 s1"}, cand1S1, e.s11);
    end
  endtask

  // one clock: compare the result of inputs from two negedges ago, then drive
  task automatic step(input logic [S-1:0] a3, a2, input logic [N1-1:0] a1,
                      input logic [N4-1:0] a4, a5,
                      input logic [2:0] v1, v2, v4, v5, input string tag);
    @(negedge clk);
    if (expQ.size() == 2) compareOut(expQ.pop_front(), tagQ.pop_front());
    hitS3 = a3; hitS2 = a2; hitS1 = a1; hitS4 = a4; hitS5 = a5;
    win1 = v1; win2 = v2; win4 = v4; win5 = v5;
    expQ.push_back(refModel(a3, a2, a1, a4, a5, int'(v1), int'(v2), int'(v4), int'(v5)));
    tagQ.push_back(tag);
  endtask

  task automatic flush();
    repeat (2) step('0, '0, '0, '0, '0, 3'd0, 3'd0, 3'd0, 3'd0, "flush");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(!cand0Valid && !cand1Valid, "R7 reset valids", {cand1Valid, cand0Valid}, 0);
    rstN = 1'b1;

    // R6: single track seed 5, visible exactly two edges later
    hitS3 = S'(1) << 5; hitS2 = S'(1) << 5; hitS1 = N1'(1) << 2;
    hitS4 = N4'(1) << 1; hitS5 = N4'(1) << 1;
    @(negedge clk);
    hitS3 = '0; hitS2 = '0; hitS1 = '0; hitS4 = '0; hitS5 = '0;
    check(!cand0Valid, "R6 not yet after one edge", cand0Valid, 0);
    @(negedge clk);
    check(cand0Valid && cand0Seed == 8'd5, "R6 valid after two edges", cand0Seed, 5);
    check(cand0S1Valid && cand0S1 == 8'd2, "R6 s1 of latency track", cand0S1, 2);

    // R4: zero width sees only the centre pad
    step(S'(1), S'(2), '0, N4'(1), N4'(1), 3'd0, 3'd0, 3'd0, 3'd0, "R4 width0");
    step(S'(1), S'(2), '0, N4'(1), N4'(1), 3'd0, 3'd1, 3'd0, 3'd0, "R4 width1");
    // R4: edge seed, window reaching past both ends of the tower
    step(S'(1) << (S - 1), S'(1) << (S - 1), N1'(1) << (N1 - 1), N4'(1) << (N4 - 1),
         N4'(1) << (N4 - 1), 3'd7, 3'd7, 3'd7, 3'd7, "R4 top edge");
    // R2 and R3: equal-distance ties pick the lower index
    step(S'(1) << 10, (S'(1) << 8) | (S'(1) << 12), (N1'(1) << 2) | (N1'(1) << 4),
         N4'(1) << 2, N4'(1) << 2, 3'd1, 3'd2, 3'd0, 3'd0, "R2 tie");
    // R3: no station-one hit, still a candidate
    step(S'(1) << 10, S'(1) << 12, '0, N4'(1) << 2, N4'(1) << 2,
         3'd3, 3'd2, 3'd0, 3'd0, "R3 no s1");
    // R1: station five missing, no track
    step(S'(1) << 10, S'(1) << 10, '0, N4'(1) << 2, '0, 3'd0, 3'd0, 3'd0, 3'd7, "R1 missing s5");
    // R5: three accepted seeds, third dropped
    step((S'(1) << 4) | (S'(1) << 8) | (S'(1) << 12), (S'(1) << 4) | (S'(1) << 8) | (S'(1) << 12),
         '1, '1, '1, 3'd0, 3'd0, 3'd0, 3'd0, "R5 three seeds");
    flush();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [S-1:0] r3, r2;
      logic [N1-1:0] r1;
      logic [N4-1:0] r4, r5;
      r3 = S'($urandom) & S'($urandom);
      r2 = S'($urandom) & S'($urandom) & S'($urandom);
      r1 = N1'($urandom) & N1'($urandom);
      r4 = N4'($urandom) & N4'($urandom);
      r5 = N4'($urandom) & N4'($urandom);
      step(r3, r2, r1, r4, r5, 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), "random");
    end
    flush();

    // R7: reset mid-run clears outputs
    @(negedge clk);
    hitS3 = '1; hitS2 = '1; hitS1 = '1; hitS4 = '1; hitS5 = '1;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!cand0Valid && !cand1Valid, "R7 reset mid-run", {cand1Valid, cand0Valid}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule